// File: doc/BRIEF.md
# RTC CMOS RAM Access Guard

The guard sits between an I/O port bus and a 256-byte battery-backed RAM. That RAM holds a standard lower bank of 128 bytes and an extended upper bank of 128 bytes. Each bank is reached through its own pair of ports. One port of the pair is an index port, which latches a 7-bit byte index. The other is a data port, which reads or writes the byte that the index selects. The guard turns data-port accesses into single-cycle RAM strobes. It presents an 8-bit RAM address whose top bit selects the upper bank.

A small configuration register, written through a plain write port, controls what the bus may reach. One bit opens the upper bank's port pair. Two sticky bits each seal the eight bytes at indices 38h to 3Fh, one bit for each bank. A sealed or closed access never strobes the RAM. A read of such a byte returns FFh instead of the stored value. Once a seal bit is set, only a hardware reset clears it. This lets firmware keep secrets in those bytes and then hide them for the rest of the session.

Top module: `rtc_ram_guard`

## Requirements
- R1: After reset the configuration reads 00h, both index registers are 0, no RAM strobe is active and io_rvalid is 0.
- R2: The configuration register holds bit 2 (upper bank open), bit 3 (lower seal) and bit 4 (upper seal). Bits 7:5 and 1:0 always read 0 and ignore writes. Bit 2 follows every write.
- R3: The seal bits are write-once. Writing 1 sets a seal bit at the write's clock edge, and writing 0 leaves a set bit set. Only reset clears them. A new seal applies to accesses from the cycle after the write.
- R4: Port 70h is the lower index, 71h the lower data, 72h the upper index and 73h the upper data. An access to any other port produces no strobe and no io_rvalid.
- R5: An allowed data-port write raises ram_we in the same cycle. It drives ram_addr = {bank, index}, where bank is 1 for the upper bank, and ram_wdata = io_wdata.
- R6: An allowed data-port read raises ram_re in the same cycle with the same address. One cycle later, io_rvalid is 1 and io_rdata equals ram_rdata.
- R7: While a bank's seal bit is set, data accesses to indices 38h-3Fh of that bank give no strobe. A read of such an index returns FFh. Indices 37h and 40h stay reachable.
- R8: While bit 2 is 0, port 73h accesses give no strobe and its reads return FFh. Index writes to 72h are dropped, and the upper index keeps its value.
- R9: An index-port write latches io_wdata bits 6:0 and ignores bit 7. An index-port read gives no strobe and returns FFh one cycle later.
- R10: Every read of ports 70h-73h gives io_rvalid exactly one cycle later. Writes never raise io_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_rdata | output | 8 | Current configuration value |
| io_valid | input | 1 | I/O access present this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 8 | I/O port number |
| io_wdata | input | 8 | I/O write data |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 8 | Read response data |
| ram_addr | output | 8 | RAM byte address, bit 7 = upper bank |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after ram_re |

## Verification
The RAM strobes, the address and the write data are combinational in the request cycle. The bench compares them two time units after it drives a request, before the clock edge. Index and configuration writes take effect at that edge, and read responses appear one cycle later. The bench therefore compares io_rvalid, io_rdata and cfg_rdata at the next falling edge, against a behavioural model that it has advanced at the rising edge. The bench's RAM survives a mid-test reset. Reading after the reset shows that writes into sealed bytes never reached storage.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;

    // Bit positions in the configuration byte (decoded by software).
    localparam int unsigned CFG_BIT_HI_EN   = 2;
    localparam int unsigned CFG_BIT_LOCK_LO = 3;
    localparam int unsigned CFG_BIT_LOCK_HI = 4;

    typedef enum logic [2:0] {
        PT_NONE   = 3'd0,
        PT_LO_IDX = 3'd1,
        PT_LO_DAT = 3'd2,
        PT_HI_IDX = 3'd3,
        PT_HI_DAT = 3'd4
    } port_kind_e;

    typedef struct packed {
        logic lock_hi;
        logic lock_lo;
        logic hi_en;
    } cfg_t;

    typedef struct packed {
        logic rvalid;
        logic pass;
    } rd_track_t;

endpackage

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg
    import rtc_guard_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              hi_en,
    output logic              lock_lo,
    output logic              lock_hi
);

    cfg_t cfg_d, cfg_q;
    logic rsvd_unused;

    // Only three bits carry state; the rest are dropped on purpose.
    assign rsvd_unused = ^{cfg_wdata[DATA_W-1:CFG_BIT_LOCK_HI+1],
                           cfg_wdata[CFG_BIT_HI_EN-1:0]};

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d.hi_en   = cfg_wdata[CFG_BIT_HI_EN];
            cfg_d.lock_lo = cfg_q.lock_lo | cfg_wdata[CFG_BIT_LOCK_LO];
            cfg_d.lock_hi = cfg_q.lock_hi | cfg_wdata[CFG_BIT_LOCK_HI];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_rdata                  = '0;
        cfg_rdata[CFG_BIT_HI_EN]   = cfg_q.hi_en;
        cfg_rdata[CFG_BIT_LOCK_LO] = cfg_q.lock_lo;
        cfg_rdata[CFG_BIT_LOCK_HI] = cfg_q.lock_hi;
    end

    assign hi_en   = cfg_q.hi_en;
    assign lock_lo = cfg_q.lock_lo;
    assign lock_hi = cfg_q.lock_hi;

    AST_LOCK_LO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lo |=> lock_lo); // R3
    AST_LOCK_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hi |=> lock_hi); // R3
    AST_HI_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (hi_en == $past(cfg_wdata[CFG_BIT_HI_EN]))); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[DATA_W-1:CFG_BIT_LOCK_HI+1] == '0)
        && (cfg_rdata[CFG_BIT_HI_EN-1:0] == '0)); // R2

endmodule

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
    import rtc_guard_pkg::*;
#(
    parameter int unsigned   PORT_W    = 8,
    parameter int unsigned   IDX_W     = 7,
    parameter logic [7:0]    PORT_BASE = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_addr,
    input  logic [IDX_W-1:0]  idx_wdata,
    input  logic              hi_en,
    output port_kind_e        kind,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [IDX_W-1:0]  hi_idx
);

    localparam logic [PORT_W-1:0] P_LO_IDX = PORT_W'(PORT_BASE);
    localparam logic [PORT_W-1:0] P_LO_DAT = PORT_W'(PORT_BASE + 8'd1);
    localparam logic [PORT_W-1:0] P_HI_IDX = PORT_W'(PORT_BASE + 8'd2);
    localparam logic [PORT_W-1:0] P_HI_DAT = PORT_W'(PORT_BASE + 8'd3);

    typedef struct packed {
        logic [IDX_W-1:0] lo;
        logic [IDX_W-1:0] hi;
    } idx_regs_t;

    idx_regs_t idx_d, idx_q;

    always_comb begin
        kind = PT_NONE;
        if (io_valid) begin
            unique case (io_addr)
                P_LO_IDX: kind = PT_LO_IDX;
                P_LO_DAT: kind = PT_LO_DAT;
                P_HI_IDX: kind = PT_HI_IDX;
                P_HI_DAT: kind = PT_HI_DAT;
                default:  kind = PT_NONE;
            endcase
        end
    end

    always_comb begin
        idx_d = idx_q;
        if (io_write) begin
            if (kind == PT_LO_IDX)           idx_d.lo = idx_wdata;
            if (kind == PT_HI_IDX && hi_en)  idx_d.hi = idx_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign lo_idx = idx_q.lo;
    assign hi_idx = idx_q.hi;

    AST_HI_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_en |=> $stable(hi_idx)); // R8
    AST_LO_IDX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_addr == P_LO_IDX)
        |=> (lo_idx == $past(idx_wdata))); // R9

endmodule

// File: rtl/rtc_ram_ctl.sv
module rtc_ram_ctl
    import rtc_guard_pkg::*;
#(
    parameter int unsigned      DATA_W     = 8,
    parameter int unsigned      IDX_W      = 7,
    parameter logic [IDX_W-1:0] LOCK_FIRST = 7'h38,
    parameter logic [IDX_W-1:0] LOCK_LAST  = 7'h3F,
    localparam int unsigned     ADDR_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_kind_e        kind,
    input  logic              io_write,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic              hi_en,
    input  logic              lock_lo,
    input  logic              lock_hi,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              io_rvalid,
    output logic [DATA_W-1:0] io_rdata
);

    logic             sel_hi;
    logic [IDX_W-1:0] cur_idx;
    logic             in_win;
    logic             bank_locked;
    logic             bank_open;
    logic             is_data;
    logic             pass;

    rd_track_t rd_d, rd_q;

    always_comb begin
        sel_hi      = (kind == PT_HI_DAT);
        cur_idx     = sel_hi ? hi_idx : lo_idx;
        in_win      = (cur_idx >= LOCK_FIRST) && (cur_idx <= LOCK_LAST);
        bank_locked = sel_hi ? lock_hi : lock_lo;
        bank_open   = !sel_hi || hi_en;
        is_data     = (kind == PT_LO_DAT) || (kind == PT_HI_DAT);
        pass        = is_data && bank_open && !(in_win && bank_locked);
    end

    assign ram_addr  = {sel_hi, cur_idx};
    assign ram_we    = pass && io_write;
    assign ram_re    = pass && !io_write;
    assign ram_wdata = io_wdata;

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = (kind != PT_NONE) && !io_write;
        rd_d.pass   = ram_re;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign io_rvalid = rd_q.rvalid;
    assign io_rdata  = rd_q.rvalid ? (rd_q.pass ? ram_rdata : '1) : '0;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re)); // R5
    AST_NO_LOCKED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |->
        !((ram_addr[IDX_W-1:0] >= LOCK_FIRST) && (ram_addr[IDX_W-1:0] <= LOCK_LAST)
          && (ram_addr[IDX_W] ? lock_hi : lock_lo))); // R7
    AST_UPPER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((ram_we || ram_re) && ram_addr[IDX_W]) |-> hi_en); // R8
    AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((kind != PT_NONE) && !io_write) |=> io_rvalid); // R10
    AST_BLOCKED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rvalid && !$past(ram_re)) |-> (io_rdata == '1)); // R7

endmodule

// File: rtl/rtc_ram_guard.sv
module rtc_ram_guard
    import rtc_guard_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned PORT_W    = 8,
    parameter int unsigned IDX_W     = 7,
    parameter logic [7:0]  PORT_BASE = 8'h70,
    localparam int unsigned ADDR_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [PORT_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              io_rvalid,
    output logic [DATA_W-1:0] io_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              ram_re,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);

    logic             hi_en, lock_lo, lock_hi;
    port_kind_e       kind;
    logic [IDX_W-1:0] lo_idx, hi_idx;

    rtc_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .hi_en     (hi_en),
        .lock_lo   (lock_lo),
        .lock_hi   (lock_hi)
    );

    rtc_port_decode #(
        .PORT_W    (PORT_W),
        .IDX_W     (IDX_W),
        .PORT_BASE (PORT_BASE)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_valid  (io_valid),
        .io_write  (io_write),
        .io_addr   (io_addr),
        .idx_wdata (io_wdata[IDX_W-1:0]),
        .hi_en     (hi_en),
        .kind      (kind),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx)
    );

    rtc_ram_ctl #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .io_write  (io_write),
        .io_wdata  (io_wdata),
        .lo_idx    (lo_idx),
        .hi_idx    (hi_idx),
        .hi_en     (hi_en),
        .lock_lo   (lock_lo),
        .lock_hi   (lock_hi),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .ram_wdata (ram_wdata),
        .io_rvalid (io_rvalid),
        .io_rdata  (io_rdata)
    );

endmodule

// File: tb/rtc_ram_guard_tb.sv
module rtc_ram_guard_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       io_valid = 1'b0, io_write = 1'b0;
    logic [7:0] io_addr = '0, io_wdata = '0;
    logic       io_rvalid;
    logic [7:0] io_rdata;
    logic [7:0] ram_addr, ram_wdata;
    logic       ram_we, ram_re;
    logic [7:0] ram_rdata = '0;

    always #5 clk = ~clk;

    rtc_ram_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_valid(io_valid), .io_write(io_write), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Battery-backed storage driven by the DUT strobes; survives reset.
    logic [7:0] ram_arr [256];
    always @(posedge clk) begin
        if (ram_we) ram_arr[ram_addr] <= ram_wdata;
        ram_rdata <= ram_re ? ram_arr[ram_addr] : 8'h00;
    end

    // Behavioural reference state.
    logic [7:0] ref_mem [256];
    bit         m_en, m_llo, m_lhi;
    bit   [6:0] m_lidx, m_hidx;
    bit         m_rv;
    bit   [7:0] m_rd;
    int         checks = 0, fails = 0;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit in_win(bit [6:0] i);
        return (i >= 7'h38) && (i <= 7'h3F);
    endfunction

    function automatic logic [7:0] m_cfg();
        return {3'b000, m_lhi, m_llo, m_en, 2'b00};
    endfunction

    // One bus cycle; entered and left at a falling edge.
    task automatic step(bit v, bit w, logic [7:0] a, logic [7:0] d,
                        bit cw = 0, logic [7:0] cd = 8'h00);
        bit e_we = 0, e_re = 0, e_rv = 0;
        bit [7:0] e_addr = '0;
        string tag = "R4";
        io_valid = v; io_write = w; io_addr = a; io_wdata = d;
        cfg_we = cw; cfg_wdata = cd;
        #2;
        if (v) begin
            case (a)
                8'h70, 8'h72: begin tag = w ? "R9" : "R9"; e_rv = !w; end
                8'h71: begin
                    e_rv = !w;
                    if (m_llo && in_win(m_lidx)) tag = "R7";
                    else begin
                        tag = w ? "R5" : "R6"; e_addr = {1'b0, m_lidx};
                        e_we = w; e_re = !w;
                    end
                end
                8'h73: begin
                    e_rv = !w;
                    if (!m_en) tag = "R8";
                    else if (m_lhi && in_win(m_hidx)) tag = "R7";
                    else begin
                        tag = w ? "R5" : "R6"; e_addr = {1'b1, m_hidx};
                        e_we = w; e_re = !w;
                    end
                end
                default: tag = "R4";
            endcase
        end
        chk({tag, " ram_we"}, {7'b0, ram_we}, {7'b0, e_we});
        chk({tag, " ram_re"}, {7'b0, ram_re}, {7'b0, e_re});
        if (e_we || e_re) chk({tag, " ram_addr"}, ram_addr, e_addr);
        if (e_we) chk({tag, " ram_wdata"}, ram_wdata, d);
        @(posedge clk);
        m_rd = e_re ? ref_mem[e_addr] : 8'hFF;
        m_rv = e_rv;
        if (e_we) ref_mem[e_addr] = d;
        if (v && w && a == 8'h70) m_lidx = d[6:0];
        if (v && w && a == 8'h72 && m_en) m_hidx = d[6:0];
        if (cw) begin
            m_en  = cd[2];
            m_llo = m_llo | cd[3];
            m_lhi = m_lhi | cd[4];
        end
        @(negedge clk);
        io_valid = 0; cfg_we = 0;
        chk({tag, " R10 io_rvalid"}, {7'b0, io_rvalid}, {7'b0, m_rv});
        if (m_rv) chk({tag, " io_rdata"}, io_rdata, m_rd);
        chk((m_llo || m_lhi) ? "R3 cfg" : "R2 cfg", cfg_rdata, m_cfg());
    endtask

    task automatic do_reset();
        rst_n = 0; io_valid = 0; cfg_we = 0;
        repeat (2) @(negedge clk);
        m_en = 0; m_llo = 0; m_lhi = 0; m_lidx = 0; m_hidx = 0; m_rv = 0;
        chk("R1 cfg", cfg_rdata, 8'h00);
        chk("R1 ram_we", {7'b0, ram_we}, 8'h00);
        chk("R1 ram_re", {7'b0, ram_re}, 8'h00);
        chk("R1 io_rvalid", {7'b0, io_rvalid}, 8'h00);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] port, logic [7:0] d); step(1, 1, port, d); endtask
    task automatic rd(logic [7:0] port); step(1, 0, port, 8'h00); endtask
    task automatic cfg(logic [7:0] d); step(0, 0, 8'h00, 8'h00, 1, d); endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram_arr[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        @(negedge clk);
        do_reset();                              // R1
        // R1: lower index starts at 0
        rd(8'h71);
        // R2: reserved bits ignored, bit 2 follows
        cfg(8'hE3);
        cfg(8'h04);
        // R5 R6 lower bank, including window edges while unlocked
        foreach (ref_mem[k]) if (k < 0) break;
        for (int j = 0; j < 6; j++) begin
            logic [7:0] ix [6] = '{8'h00, 8'h37, 8'h38, 8'h3F, 8'h40, 8'h7F};
            wr(8'h70, ix[j]); wr(8'h71, 8'hA0 + 8'(j)); rd(8'h71);
            wr(8'h72, ix[j]); wr(8'h73, 8'hC0 + 8'(j)); rd(8'h73);
        end
        // R9: bit 7 of index ignored; index port reads give FFh
        wr(8'h70, 8'hB8); rd(8'h71); rd(8'h70); rd(8'h72);
        // R4: foreign ports
        rd(8'h74); wr(8'h6F, 8'h11); rd(8'h80);
        // R8: upper bank closed
        wr(8'h72, 8'h10); wr(8'h73, 8'h77);
        cfg(8'h00);
        wr(8'h72, 8'h20); rd(8'h73); wr(8'h73, 8'h99);
        cfg(8'h04);
        rd(8'h73);                               // index still 10h
        // R3 R7: seal lower bank; write to 38h in same cycle as seal
        wr(8'h70, 8'h38);
        step(1, 1, 8'h71, 8'h3C, 1, 8'h0C);      // seal applies next cycle
        rd(8'h71); wr(8'h71, 8'hEE); rd(8'h71);
        wr(8'h70, 8'h3F); wr(8'h71, 8'hEF); rd(8'h71);
        wr(8'h70, 8'h37); wr(8'h71, 8'h37); rd(8'h71);
        wr(8'h70, 8'h40); wr(8'h71, 8'h40); rd(8'h71);
        cfg(8'h04);                              // cannot clear
        wr(8'h72, 8'h38); wr(8'h73, 8'h55); rd(8'h73);   // upper still open
        cfg(8'h14);
        wr(8'h73, 8'h66); rd(8'h73);
        wr(8'h72, 8'h3A); rd(8'h73);
        wr(8'h72, 8'h41); rd(8'h73);
        cfg(8'h00);                              // locks stay, bank closes
        // R1 R7: reset clears seals; storage kept its pre-seal values
        do_reset();
        cfg(8'h04);
        wr(8'h70, 8'h38); rd(8'h71);
        wr(8'h70, 8'h3F); rd(8'h71);
        wr(8'h72, 8'h38); rd(8'h73);
        wr(8'h72, 8'h3A); rd(8'h73);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule